// File: doc/BRIEF.md
# Addressed Step-Attenuator Control Logic

This block is the digital front end of a 7-bit step attenuator. It holds a registered attenuation code and takes new values from one of two sources, picked by a mode input. In serial mode a three-wire stream (bit clock, data, latch) fills a 16-bit frame. A rising latch edge commits the frame's attenuation bits, but only when the frame's 3-bit address equals the strapped address of this device. Up to eight devices can therefore share one bus. In parallel mode the latch input selects how the code follows seven control pins. With latch high the code tracks the pins directly. With latch low the pins are ignored until the next rising latch edge, which captures them.

All inputs are resynchronized into a fast system clock, which must run at least four times the serial bit clock. Edges of the bit clock and the latch are detected in that domain. The code weights run from 0.25 dB for bit 0 up to 16 dB for bit 6, and a 1 switches a section in. At reset the code sits at maximum attenuation.

Top module: `stepatt_top`

## Requirements
- R1: After reset the attenuation code is 0x7F, and it stays there until a load event occurs.
- R2: In serial mode (modeSerial=1) data is shifted LSB first on rising serClk edges while serLatch is low. After 16 bits the attenuation byte is in frame bits 7:0 and the address byte is in bits 15:8. On a rising serLatch edge with frame bits 10:8 equal to strapAddr, the code takes frame bits 6:0; frame bit 7 is discarded.
- R3: On a rising serLatch edge whose frame bits 10:8 differ from strapAddr, the code keeps its value. Frame bits 15:11 never affect the comparison.
- R4: While serLatch is high, serClk edges do not shift the frame register.
- R5: In parallel mode (modeSerial=0) with serLatch high, the code follows parCode.
- R6: In parallel mode with serLatch low, parCode changes are ignored; a rising serLatch edge captures parCode.
- R7: If reset ends in parallel mode with serLatch low, the code stays at 0x7F until the first rising serLatch edge.
- R8: A change of modeSerial alone leaves the code unchanged, except that a switch to parallel mode while serLatch is high applies direct tracking at once.
- R9: The frame register is cleared by reset and no bit count is enforced. A frame cut short is committed from the bits just shifted in plus the older contents pushed down toward bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial bit clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSerial | input | 1 | 1 selects serial control, 0 selects parallel control |
| serClk | input | 1 | Serial bit clock; rising edge shifts |
| serData | input | 1 | Serial data, LSB of each byte first |
| serLatch | input | 1 | Serial commit strobe and parallel direct/latched select |
| parCode | input | 7 | Parallel attenuation code |
| strapAddr | input | 3 | Hard-wired device address |
| attenCode | output | 7 | Registered attenuation code, 1 = section in |

## Verification
The serial path is driven with frames whose address bytes match the strap and with frames that differ only in the low three bits. The address bytes also set the upper don't-care bits, so a comparison that is too wide or too narrow shows up. A frame is clocked in while the latch is held high and then recommitted. This separates a gated shift register from a free-running one. A half-length frame separates a right-shifting, LSB-first register from other orderings. In parallel mode, pin changes made with the latch high and with the latch low separate direct tracking from latched capture. Mode switches at both latch levels confirm when the code is held and when it is updated.

// File: rtl/stepatt_pkg.sv
package stepatt_pkg;
  // Strobes handed from control to datapath, at most one active per cycle.
  typedef struct packed {
    logic shiftEn;    // push one serial bit into the frame register
    logic serCommit;  // addressed commit of the frame
    logic parLoad;    // load the code from the parallel pins
  } stepStrobes_t;
endpackage

// File: rtl/stepatt_sync.sv
module stepatt_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= RST_VAL;
          else       stage[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= RST_VAL;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/stepatt_ctl.sv
module stepatt_ctl
  import stepatt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sMode,
  input  logic         sClk,
  input  logic         sLatch,
  output stepStrobes_t strb
);
  logic clkPrev;
  logic latchPrev;

  // Previous values reset high so an input already high at reset is not an edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev   <= 1'b1;
      latchPrev <= 1'b1;
    end else begin
      clkPrev   <= sClk;
      latchPrev <= sLatch;
    end
  end

  always_comb begin
    strb           = '0;
    strb.shiftEn   = sMode & ~sLatch & sClk & ~clkPrev;
    strb.serCommit = sMode & sLatch & ~latchPrev;
    // A rising latch edge and a held-high latch both load in parallel mode.
    strb.parLoad   = ~sMode & sLatch;
  end
endmodule

// File: rtl/stepatt_dp.sv
module stepatt_dp
  import stepatt_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int ADDR_W = 3,
  parameter int WORD_W = 8,
  localparam int FRAME_W = 2 * WORD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  stepStrobes_t       strb,
  input  logic               sData,
  input  logic [CODE_W-1:0]  sPar,
  input  logic [ADDR_W-1:0]  strapAddr,
  output logic [CODE_W-1:0]  attenCode,
  output logic [FRAME_W-1:0] frameBits
);
  logic addrHit;

  assign addrHit = (frameBits[WORD_W +: ADDR_W] == strapAddr);

  // New bits enter at the top so the first bit sent ends at bit 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameBits <= '0;
    else if (strb.shiftEn) frameBits <= {sData, frameBits[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) attenCode <= '1;
    else if (strb.serCommit && addrHit) attenCode <= frameBits[CODE_W-1:0];
    else if (strb.parLoad) attenCode <= sPar;
  end
endmodule

// File: rtl/stepatt_top.sv
module stepatt_top
  import stepatt_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int ADDR_W = 3,
  parameter int WORD_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSerial,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLatch,
  input  logic [CODE_W-1:0] parCode,
  input  logic [ADDR_W-1:0] strapAddr,
  output logic [CODE_W-1:0] attenCode
);
  localparam int FRAME_W = 2 * WORD_W;
  localparam int SYNC_W  = CODE_W + 4;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b1, 1'b1, 1'b0, {CODE_W{1'b0}}};

  logic [SYNC_W-1:0]  syncOut;
  logic               sMode, sLatch, sClk, sData;
  logic [CODE_W-1:0]  parSync;
  logic [FRAME_W-1:0] frameBits;
  stepStrobes_t       strb;

  stepatt_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({modeSerial, serLatch, serClk, serData, parCode}),
    .dout(syncOut)
  );

  assign {sMode, sLatch, sClk, sData, parSync} = syncOut;

  stepatt_ctl u_ctl (
    .clk(clk), .rstN(rstN), .sMode(sMode), .sClk(sClk), .sLatch(sLatch), .strb(strb)
  );

  stepatt_dp #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sData(sData), .sPar(parSync),
    .strapAddr(strapAddr), .attenCode(attenCode), .frameBits(frameBits)
  );
endmodule

// File: rtl/stepatt_chk.sv
module stepatt_chk
  import stepatt_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int ADDR_W = 3,
  parameter int WORD_W = 8,
  localparam int FRAME_W = 2 * WORD_W
) (
  input logic               clk,
  input logic               rstN,
  input logic [CODE_W-1:0]  attenCode,
  input stepStrobes_t       strb,
  input logic [FRAME_W-1:0] frameBits,
  input logic [ADDR_W-1:0]  strapAddr,
  input logic [CODE_W-1:0]  parSync
);
  assert_reset_max_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> attenCode == '1);

  assert_match_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.serCommit && frameBits[WORD_W +: ADDR_W] == strapAddr)
      |=> attenCode == $past(frameBits[CODE_W-1:0]));

  assert_mismatch_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.serCommit && frameBits[WORD_W +: ADDR_W] != strapAddr) |=> $stable(attenCode));

  assert_no_shift_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftEn |=> $stable(frameBits));

  assert_direct_follow_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.parLoad |=> attenCode == $past(parSync));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.serCommit && !strb.parLoad) |=> $stable(attenCode));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftEn, strb.serCommit, strb.parLoad}));
endmodule

bind stepatt_top stepatt_chk #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .attenCode(attenCode), .strb(strb),
  .frameBits(frameBits), .strapAddr(strapAddr), .parSync(parSync)
);

// File: tb/sim_stepatt_top.sv
`timescale 1ns/1ps
module sim_stepatt_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeSerial = 1'b0;
  logic       serClk = 1'b0;
  logic       serData = 1'b0;
  logic       serLatch = 1'b0;
  logic [6:0] parCode = 7'h12;
  logic [2:0] strapAddr = 3'd3;
  logic [6:0] attenCode;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  stepatt_top u0 (
    .clk(clk), .rstN(rstN), .modeSerial(modeSerial), .serClk(serClk),
    .serData(serData), .serLatch(serLatch), .parCode(parCode),
    .strapAddr(strapAddr), .attenCode(attenCode)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [6:0] exp);
    checks++;
    if (attenCode !== exp) begin
      fails++;
      $display("FAIL %s: attenCode=0x%02h expected 0x%02h", tag, attenCode, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    waitCyc(3);
    serClk = 1'b1;
    waitCyc(4);
    serClk = 1'b0;
    waitCyc(3);
  endtask

  task automatic sendBits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) sendBit(v[i]);
  endtask

  task automatic sendFrame(input logic [7:0] attn, input logic [7:0] addr, input int n);
    serLatch = 1'b0;
    waitCyc(4);
    sendBits({addr, attn}, n);
    waitCyc(4);
    serLatch = 1'b1;
    waitCyc(8);
  endtask

  task automatic tPowerUpParallel();
    waitCyc(10);
    check("R1 reset code", 7'h7F);
    parCode = 7'h33;
    waitCyc(8);
    check("R7 latch low after reset holds max", 7'h7F);
  endtask

  task automatic tLatchedParallel();
    serLatch = 1'b1;
    waitCyc(8);
    check("R6 capture on latch rise", 7'h33);
  endtask

  task automatic tDirectParallel();
    parCode = 7'h55;
    waitCyc(8);
    check("R5 direct follow 0x55", 7'h55);
    parCode = 7'h0A;
    waitCyc(8);
    check("R5 direct follow 0x0A", 7'h0A);
    serLatch = 1'b0;
    waitCyc(8);
    parCode = 7'h7F;
    waitCyc(8);
    check("R6 latch low ignores pins", 7'h0A);
    serLatch = 1'b1;
    waitCyc(8);
    check("R6 second capture", 7'h7F);
    serLatch = 1'b0;
    parCode = 7'h21;
    waitCyc(8);
  endtask

  task automatic tModeToSerial();
    modeSerial = 1'b1;
    waitCyc(8);
    check("R8 mode change keeps code", 7'h7F);
    serLatch = 1'b1;
    waitCyc(8);
    check("R3 empty frame addr 0 vs strap 3 keeps code", 7'h7F);
  endtask

  task automatic tSerialMatch();
    sendFrame(8'hA5, 8'hF3, 16);
    check("R2 matched frame, bit7 dropped, high addr bits ignored", 7'h25);
  endtask

  task automatic tSerialMismatch();
    sendFrame(8'h3C, 8'h04, 16);
    check("R3 address mismatch keeps code", 7'h25);
    strapAddr = 3'd4;
    sendFrame(8'h3C, 8'h04, 16);
    check("R3 strap 4 matches addr 4", 7'h3C);
    strapAddr = 3'd3;
  endtask

  task automatic tLatchHighIgnored();
    sendFrame(8'h11, 8'h03, 16);
    check("R2 frame 0x11", 7'h11);
    sendBits({8'h03, 8'h2A}, 16);
    serLatch = 1'b0;
    waitCyc(6);
    serLatch = 1'b1;
    waitCyc(8);
    check("R4 clocks with latch high not shifted", 7'h11);
  endtask

  task automatic tShortFrame();
    sendFrame(8'h0B, 8'h00, 8);
    check("R9 half frame uses shifted-down old bits", 7'h03);
  endtask

  task automatic tSerToParDirect();
    parCode = 7'h66;
    waitCyc(4);
    modeSerial = 1'b0;
    waitCyc(8);
    check("R8 to parallel with latch high goes direct", 7'h66);
    modeSerial = 1'b1;
    parCode = 7'h01;
    waitCyc(8);
    check("R8 back to serial keeps code", 7'h66);
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    tPowerUpParallel();
    tLatchedParallel();
    tDirectParallel();
    tModeToSerial();
    tSerialMatch();
    tSerialMismatch();
    tLatchHighIgnored();
    tShortFrame();
    tSerToParDirect();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule